// File: doc/BRIEF.md
# Divider-Gated Initial Reset Generator

This block produces the chip-wide internal initial reset. Two events can start a reset. The first is an active-low external reset pin. The second is an optional key chord: every key input held low together. A set/reset flop holds the reset once either event occurs. The pin sets it asynchronously, so the reset asserts even when no oscillator edge arrives. The flop is cleared only while the slow divider tap (the 2 Hz phase when the divider is fed with 32.768 kHz) is high. The pin must also have returned high through a two-stage synchronizer, and no chord may be asserting the reset.

The divider is a free-running binary counter on the oscillator clock. It is held at zero while the pin is low or not yet synchronized, so the release delay after the pin rises is fixed. The chord path passes through two stages before it can set the reset:

- A noise filter. The chord must be stable for `NF` consecutive cycles before the filter passes it.
- An authorization state machine. It must see two rising edges of the 1 Hz tap while the filtered chord stays present.

The state machine has four states:

- `AUTH_IDLE`: filter not passing.
- `AUTH_ARM`: chord passing, waiting for the first 1 Hz rising edge.
- `AUTH_HOLD`: one edge seen.
- `AUTH_FIRE`: authorized, and the reset is being set.

The state machine moves between states as follows:

- From `AUTH_IDLE` or `AUTH_ARM`: a 1 Hz rise moves to `AUTH_HOLD`. Otherwise it goes to or stays in `AUTH_ARM`.
- From `AUTH_HOLD`: a 1 Hz rise moves to `AUTH_FIRE`. Otherwise it stays in `AUTH_HOLD`.
- `AUTH_FIRE` stays in `AUTH_FIRE`.
- Loss of the filtered chord returns any state to `AUTH_IDLE`.

Top module: `irg_reset_gen`

## Requirements
- R1: A low level on `rst_pin_n` drives `init_rst_o` high at once, without waiting for a clock edge, and keeps it high while the pin stays low.
- R2: After `rst_pin_n` rises between clock edges, `init_rst_o` stays high for the next 2^(DIV_W-2)+2 rising edges. It falls at edge 2^(DIV_W-2)+3, when the divider's slow tap first goes high (8195 cycles for DIV_W=15).
- R3: The divider counter is zero while the pin is low, and for two edges after release while the synchronizer fills. `tap_2hz_o` is counter bit DIV_W-2 and `tap_1hz_o` is counter bit DIV_W-1.
- R4: With `chord_en_i` low, the key inputs have no effect on `init_rst_o`.
- R5: The chord condition (`chord_en_i` high and all `key_i` bits 0) reaches the authorizer only after being present at NF consecutive rising edges. Any break restarts the count.
- R6: The filtered chord sets the reset only after two rising edges of `tap_1hz_o` while it stays present. A chord shorter than one 1 Hz period never sets the reset.
- R7: Once authorized, the chord holds `init_rst_o` high. After the keys are released, the reset is cleared at the first edge where the slow tap is high and authorization has ended.
- R8: A pin pulse lasting only a fraction of one clock period still sets `init_rst_o`. Release then follows the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Low-frequency oscillator clock |
| rst_pin_n | input | 1 | Asynchronous active-low external reset pin |
| key_i | input | N_KEYS | Key inputs; chord when all are 0 |
| chord_en_i | input | 1 | Static enable for the key-chord reset source |
| init_rst_o | output | 1 | Internal initial reset, active high |
| tap_2hz_o | output | 1 | Divider bit DIV_W-2 |
| tap_1hz_o | output | 1 | Divider bit DIV_W-1 |

## Verification
Pin assertion takes effect within the same clock low phase, before any edge. Pin release is due exactly 2^(DIV_W-2)+3 edges after the rising pin. A chord needs NF edges of filtering, then two slow-tap rises, then one edge to enter `AUTH_FIRE` and one more edge to set the flop. A behavioural reference model steps on every rising edge and is compared with the reset and both taps at every falling edge. Separate directed checks count falling edges from the stimulus and sample exactly at the edge where each R2 transition falls due.

// File: rtl/irg_pkg.sv
package irg_pkg;

    typedef enum logic [1:0] {
        AUTH_IDLE,
        AUTH_ARM,
        AUTH_HOLD,
        AUTH_FIRE
    } auth_state_t;

endpackage

// File: rtl/irg_pin_sync.sv
module irg_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n,
    output logic pin_ok
);

    logic [STAGES-1:0] sync_q;

    // Clear at once on the pin, release through the stages on the clock
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], 1'b1};
        end
    end

    assign pin_ok = sync_q[STAGES-1];

endmodule

// File: rtl/irg_divider.sv
module irg_divider #(
    parameter int DIV_W = 15
) (
    input  logic clk,
    input  logic pin_n,
    input  logic run,
    output logic tap_slow,
    output logic tap_fast
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    assign tap_fast = cnt_q[DIV_W-2];
    assign tap_slow = cnt_q[DIV_W-1];

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!pin_n)
        !run |=> (cnt_q == '0)); // R3

    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!pin_n)
        run |=> (cnt_q == $past(cnt_q) + ONE)); // R3

endmodule

// File: rtl/irg_chord_qual.sv
module irg_chord_qual
    import irg_pkg::*;
#(
    parameter int N_KEYS = 4,
    parameter int NF     = 4
) (
    input  logic              clk,
    input  logic              pin_n,
    input  logic [N_KEYS-1:0] key_i,
    input  logic              chord_en,
    input  logic              tap_slow,
    output logic              auth
);

    localparam int          FW       = $clog2(NF + 1);
    localparam logic [FW-1:0] FLT_MAX = FW'(NF);
    localparam logic [FW-1:0] FLT_ONE = FW'(1);

    logic          keys_low;
    logic [FW-1:0] flt_q;
    logic          filt;
    logic          slow_d_q;
    logic          slow_rise;
    auth_state_t   state_q, state_d;

    assign keys_low  = chord_en && (key_i == '0);
    assign filt      = (flt_q == FLT_MAX);
    assign slow_rise = tap_slow && !slow_d_q;

    // Noise filter: saturating count of consecutive chord edges
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            flt_q    <= '0;
            slow_d_q <= 1'b0;
        end else begin
            slow_d_q <= tap_slow;
            if (!keys_low) begin
                flt_q <= '0;
            end else if (!filt) begin
                flt_q <= flt_q + FLT_ONE;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            state_q <= AUTH_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            AUTH_IDLE,
            AUTH_ARM:  state_d = slow_rise ? AUTH_HOLD : AUTH_ARM;
            AUTH_HOLD: state_d = slow_rise ? AUTH_FIRE : AUTH_HOLD;
            AUTH_FIRE: state_d = AUTH_FIRE;
        endcase
        if (!filt) begin
            state_d = AUTH_IDLE;
        end
    end

    // Outputs
    always_comb begin
        auth = (state_q == AUTH_FIRE);
    end

    AST_FILT_NEEDS_CHORD: assert property (@(posedge clk) disable iff (!pin_n)
        filt |-> $past(keys_low)); // R5

    AST_FIRE_NEEDS_FILT: assert property (@(posedge clk) disable iff (!pin_n)
        auth |-> $past(filt)); // R6

    AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (!pin_n)
        !filt |=> (state_q == AUTH_IDLE)); // R6

    AST_NO_CHORD_DISABLED: assert property (@(posedge clk) disable iff (!pin_n)
        !chord_en |=> !filt); // R4

endmodule

// File: rtl/irg_reset_gen.sv
module irg_reset_gen #(
    parameter int DIV_W       = 15,
    parameter int N_KEYS      = 4,
    parameter int NF          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              osc_clk,
    input  logic              rst_pin_n,
    input  logic [N_KEYS-1:0] key_i,
    input  logic              chord_en_i,
    output logic              init_rst_o,
    output logic              tap_2hz_o,
    output logic              tap_1hz_o
);

    logic pin_ok;
    logic tap_fast;
    logic tap_slow;
    logic chord_auth;
    logic rst_q;

    irg_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (osc_clk),
        .pin_n  (rst_pin_n),
        .pin_ok (pin_ok)
    );

    irg_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk      (osc_clk),
        .pin_n    (rst_pin_n),
        .run      (pin_ok),
        .tap_slow (tap_slow),
        .tap_fast (tap_fast)
    );

    irg_chord_qual #(
        .N_KEYS (N_KEYS),
        .NF     (NF)
    ) u_chord (
        .clk      (osc_clk),
        .pin_n    (rst_pin_n),
        .key_i    (key_i),
        .chord_en (chord_en_i),
        .tap_slow (tap_slow),
        .auth     (chord_auth)
    );

    // Set/reset hold: pin sets asynchronously, chord sets on the clock,
    // clearing only on the fast divider phase with the pin synchronized high
    always_ff @(posedge osc_clk or negedge rst_pin_n) begin
        if (!rst_pin_n) begin
            rst_q <= 1'b1;
        end else if (chord_auth) begin
            rst_q <= 1'b1;
        end else if (pin_ok && tap_fast) begin
            rst_q <= 1'b0;
        end
    end

    assign init_rst_o = rst_q;
    assign tap_2hz_o  = tap_fast;
    assign tap_1hz_o  = tap_slow;

    AST_PIN_HOLDS_RESET: assert property (@(posedge osc_clk)
        !rst_pin_n |-> rst_q); // R1

    AST_RELEASE_ON_PHASE: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
        $fell(rst_q) |-> ($past(tap_fast) && $past(pin_ok) && !$past(chord_auth))); // R2

    AST_CHORD_SETS: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
        chord_auth |=> rst_q); // R7

    AST_TAPS_IDLE_UNSYNCED: assert property (@(posedge osc_clk) disable iff (!rst_pin_n)
        !pin_ok |=> (!tap_fast && !tap_slow)); // R3

endmodule

// File: tb/irg_reset_gen_tb.sv
`timescale 1ns/100ps
module irg_reset_gen_tb;

    localparam int DW  = 6;
    localparam int NK  = 4;
    localparam int NFB = 4;
    localparam int HALF = 1 << (DW - 2);

    logic          clk = 1'b0;
    logic          rst_pin_n = 1'b1;
    logic [NK-1:0] key = '1;
    logic          chord_en = 1'b1;
    logic          rst_o, t2, t1;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    // reference model state
    bit m_s1, m_s2, m_t1d, m_q;
    int m_cnt, m_flt, m_rises;

    always #2.5 clk = ~clk;

    irg_reset_gen #(
        .DIV_W       (DW),
        .N_KEYS      (NK),
        .NF          (NFB),
        .SYNC_STAGES (2)
    ) u_dut (
        .osc_clk    (clk),
        .rst_pin_n  (rst_pin_n),
        .key_i      (key),
        .chord_en_i (chord_en),
        .init_rst_o (rst_o),
        .tap_2hz_o  (t2),
        .tap_1hz_o  (t1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    task automatic m_reset();
        m_s1 = 0; m_s2 = 0; m_t1d = 0; m_q = 1;
        m_cnt = 0; m_flt = 0; m_rises = 0;
    endtask

    task automatic m_step();
        int  tap2 = (m_cnt >> (DW - 2)) & 1;
        int  tap1 = (m_cnt >> (DW - 1)) & 1;
        bit  kl   = chord_en && (key == '0);
        bit  filt = (m_flt == NFB);
        int  rise = (tap1 == 1 && !m_t1d) ? 1 : 0;
        bit  auth = (m_rises == 2);
        if (auth) m_q = 1;
        else if (m_s2 && tap2 == 1) m_q = 0;
        m_cnt   = m_s2 ? (m_cnt + 1) % (1 << DW) : 0;
        m_s2    = m_s1;
        m_s1    = 1;
        m_rises = filt ? ((m_rises + rise > 2) ? 2 : m_rises + rise) : 0;
        m_t1d   = (tap1 == 1);
        m_flt   = kl ? ((m_flt < NFB) ? m_flt + 1 : NFB) : 0;
    endtask

    always @(negedge rst_pin_n) m_reset();

    always @(posedge clk) begin
        cyc++;
        if (!rst_pin_n) m_reset();
        else m_step();
    end

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk(rst_o === m_q, "R2 reset vs model", int'(rst_o), int'(m_q));
            chk(t2 === ((m_cnt >> (DW - 2)) & 1), "R3 slow-phase tap vs model",
                int'(t2), (m_cnt >> (DW - 2)) & 1);
            chk(t1 === ((m_cnt >> (DW - 1)) & 1), "R3 1Hz tap vs model",
                int'(t1), (m_cnt >> (DW - 1)) & 1);
        end
    end

    task automatic summary();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            summary();
        end
    end

    // pin rises at a falling edge; the release is due on rising edge HALF+3
    task automatic release_and_time(input string tag);
        @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (HALF + 2) @(negedge clk);
        chk(rst_o === 1'b1, tag, int'(rst_o), 1);
        @(negedge clk);
        chk(rst_o === 1'b0, tag, int'(rst_o), 0);
    endtask

    task automatic hold_keys(input int n, output bit saw);
        saw = 1'b0;
        @(negedge clk);
        key = '0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_o) saw = 1'b1;
        end
        key = '1;
    endtask

    initial begin
        bit saw;
        int wait_n;
        #1 rst_pin_n = 1'b0;
        #0.5;
        chk(rst_o === 1'b1, "R1 reset before any clock edge", int'(rst_o), 1);
        cmp_on = 1'b1;
        repeat (6) @(negedge clk);
        chk(rst_o === 1'b1, "R1 reset held while pin low", int'(rst_o), 1);
        chk(t2 === 1'b0 && t1 === 1'b0, "R3 taps zero while pin low", int'({t1, t2}), 0);

        // R2: deterministic release delay
        release_and_time("R2 release timing");

        // R8: sub-cycle pin pulse
        repeat (10) @(negedge clk);
        #0.5 rst_pin_n = 1'b0;
        #0.5 rst_pin_n = 1'b1;
        #0.5;
        chk(rst_o === 1'b1, "R8 short pulse sets reset", int'(rst_o), 1);
        rst_pin_n = 1'b0;
        repeat (3) @(negedge clk);
        release_and_time("R8 release after short pulse");

        // R4: chord disabled
        chord_en = 1'b0;
        hold_keys(200, saw);
        chk(saw == 1'b0, "R4 chord ignored when disabled", int'(saw), 0);
        chord_en = 1'b1;

        // R5: bursts one edge short of the filter length
        saw = 1'b0;
        for (int b = 0; b < 80; b++) begin
            @(negedge clk);
            key = '0;
            repeat (NFB - 1) begin
                @(negedge clk);
                if (rst_o) saw = 1'b1;
            end
            key = '1;
        end
        chk(saw == 1'b0, "R5 chord bursts below filter length rejected", int'(saw), 0);

        // R6: chord shorter than one 1 Hz period
        hold_keys((1 << DW) - 24, saw);
        chk(saw == 1'b0, "R6 short chord rejected", int'(saw), 0);
        repeat (5) @(negedge clk);
        hold_keys(20, saw);
        chk(saw == 1'b0, "R6 second short chord rejected", int'(saw), 0);

        // R6/R7: full chord sets then releases the reset
        @(negedge clk);
        key = '0;
        wait_n = 0;
        while (!rst_o && wait_n < 3 * (1 << DW)) begin
            @(negedge clk);
            wait_n++;
        end
        chk(rst_o === 1'b1, "R6 held chord sets reset", int'(rst_o), 1);
        chk(wait_n >= (1 << DW), "R6 chord authorized no sooner than a 1Hz period",
            wait_n, 1 << DW);
        repeat (20) @(negedge clk);
        chk(rst_o === 1'b1, "R7 reset held while chord held", int'(rst_o), 1);
        key = '1;
        wait_n = 0;
        while (rst_o && wait_n < 3 * HALF + 8) begin
            @(negedge clk);
            wait_n++;
        end
        chk(rst_o === 1'b0, "R7 reset clears after chord release", int'(rst_o), 0);
        chk(t2 === 1'b1, "R7 release aligned to slow-phase tap high", int'(t2), 1);

        repeat (10) @(negedge clk);
        summary();
    end

endmodule